// File: doc/BRIEF.md
# Prefixed Bit-Manipulation ALU

This unit executes the second-table opcodes of an 8-bit processor. These opcodes come after a prefix byte. It is purely combinational. The core supplies the 8-bit opcode, the operand value already read from the selected register or memory location, and the current zero, subtract, half-carry and carry flags. In the same cycle the unit returns the new operand value, a write-back enable, the next flag values, and a mask that says which flags the core must write.

The opcode holds fixed fields. Bits 7:6 pick the operation group. Bits 5:3 pick either one of eight rotate, shift or swap operations, or the bit index for test, clear and force. Bits 2:0 select the operand, and the core decodes them elsewhere. This unit ignores them. Each operation group has its own rule for which flags change.

Top module: `pbalu_core`

## Requirements
- R1: When opcode[7:6] is 00, opcode[5:3] selects the operation: 0 circular left rotate, 1 circular right rotate, 2 left rotate through carry, 3 right rotate through carry, 4 left shift, 5 arithmetic right shift, 6 nibble swap, 7 logical right shift.
- R2: A circular rotate moves the bit that leaves one end into the other end and also into the carry output (flags_out[0]).
- R3: A rotate through carry moves the incoming carry (flags_in[0]) into the vacated end and the bit that leaves into the carry output.
- R4: The left shift inserts 0 at bit 0. The logical right shift inserts 0 at bit 7. The arithmetic right shift keeps bit 7. In all three, the carry output is the bit shifted out.
- R5: The nibble swap exchanges operand bits 7:4 with bits 3:0 and clears the carry output.
- R6: For every opcode with opcode[7:6] = 00, flags_out[3] (zero) is 1 exactly when the result is 0, flags_out[2] and flags_out[1] are 0, flags_mask is 1111, and wr_en is 1.
- R7: The bit test (opcode[7:6] = 01) sets the zero flag to the inverse of operand bit opcode[5:3], clears subtract, sets half-carry, passes the carry through unchanged, and drives flags_mask 1110 and wr_en 0. The result equals the operand.
- R8: Bit clear (10) and bit force (11) drive operand bit opcode[5:3] to 0 or 1 respectively and leave the other bits unchanged. They set flags_mask to 0000 and wr_en to 1, and flags_out equals flags_in.
- R9: opcode[2:0] has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 8 | Second-table opcode |
| operand | input | 8 | Operand value to operate on |
| flags_in | input | 4 | Current flags {Z,N,H,C}, Z in bit 3 |
| result | output | 8 | New operand value |
| wr_en | output | 1 | Result is to be written back |
| flags_out | output | 4 | Next flags {Z,N,H,C} |
| flags_mask | output | 4 | Per-flag write enable, same bit order |

## Verification
All results are due in the same cycle as the stimulus, because no register lies between any input and any output. The bench applies each vector just after a rising clock edge and compares all four outputs at the following falling edge. This leaves half a period for the logic to settle and keeps the comparison away from the edge. The sweep covers every opcode, every operand value and both carry inputs, with the other incoming flags varied as well. Every selector value and bit index therefore appears against every data pattern.

// File: rtl/pbalu_pkg.sv
// Package: shared operation-class encoding and flag layout for the
// prefixed bit-manipulation ALU. Assumes the 8-bit opcode field layout.
package pbalu_pkg;

    // Operation classes; the first eight follow opcode[5:3] order.
    typedef enum logic [3:0] {
        CLS_ROL_CIRC  = 4'd0,
        CLS_ROR_CIRC  = 4'd1,
        CLS_ROL_CARRY = 4'd2,
        CLS_ROR_CARRY = 4'd3,
        CLS_SHL       = 4'd4,
        CLS_SHR_ARITH = 4'd5,
        CLS_NIBSWAP   = 4'd6,
        CLS_SHR_LOGIC = 4'd7,
        CLS_TEST      = 4'd8,
        CLS_CLEAR     = 4'd9,
        CLS_FORCE     = 4'd10
    } op_class_e;

    // Flag vector, zero flag in the most significant position.
    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flag_t;

endpackage

// File: rtl/pbalu_decode.sv
// Module: pbalu_decode
// Splits the opcode into an operation class and a bit index.
// Assumes opcode[7:6] selects the group and opcode[5:3] the sub-field;
// opcode[2:0] (operand selector) is decoded by the core, not here.
module pbalu_decode
    import pbalu_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic [7:0]       opcode,
    output op_class_e        cls,
    output logic [IDX_W-1:0] bit_idx
);

    logic unused_sel;

    // Operand selector is decoded elsewhere; fold it away explicitly.
    assign unused_sel = ^opcode[2:0];

    // Target bit index sits directly above the operand selector.
    assign bit_idx = opcode[3 +: IDX_W];

    // Map the group and sub-field onto a class.
    always_comb begin
        unique case (opcode[7:6])
            2'b00:   cls = op_class_e'({1'b0, opcode[5:3]});
            2'b01:   cls = CLS_TEST;
            2'b10:   cls = CLS_CLEAR;
            default: cls = CLS_FORCE;
        endcase
    end

endmodule

// File: rtl/pbalu_shifter.sv
// Module: pbalu_shifter
// Rotates, shifts and nibble swap on a DW-bit operand.
// Assumes DW is even; carry_out is 0 for the swap and for non-shift classes.
module pbalu_shifter
    import pbalu_pkg::*;
#(
    parameter int DW = 8
) (
    input  op_class_e       cls,
    input  logic [DW-1:0]   operand,
    input  logic            carry_in,
    output logic [DW-1:0]   res,
    output logic            carry_out
);

    localparam int HALF = DW / 2;

    logic msb, lsb;

    assign msb = operand[DW-1];
    assign lsb = operand[0];

    // Select the shifted value and the bit pushed out for each class.
    always_comb begin
        res       = operand;
        carry_out = 1'b0;
        unique case (cls)
            CLS_ROL_CIRC: begin
                res       = {operand[DW-2:0], msb};
                carry_out = msb;
            end
            CLS_ROR_CIRC: begin
                res       = {lsb, operand[DW-1:1]};
                carry_out = lsb;
            end
            CLS_ROL_CARRY: begin
                res       = {operand[DW-2:0], carry_in};
                carry_out = msb;
            end
            CLS_ROR_CARRY: begin
                res       = {carry_in, operand[DW-1:1]};
                carry_out = lsb;
            end
            CLS_SHL: begin
                res       = {operand[DW-2:0], 1'b0};
                carry_out = msb;
            end
            CLS_SHR_ARITH: begin
                res       = {msb, operand[DW-1:1]};
                carry_out = lsb;
            end
            CLS_NIBSWAP: begin
                res       = {operand[HALF-1:0], operand[DW-1:HALF]};
                carry_out = 1'b0;
            end
            CLS_SHR_LOGIC: begin
                res       = {1'b0, operand[DW-1:1]};
                carry_out = lsb;
            end
            default: begin
                res       = operand;
                carry_out = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pbalu_bitop.sv
// Module: pbalu_bitop
// Single-bit test, clear and force at a run-time bit index.
// Assumes bit_idx < DW; for other classes the operand passes unchanged.
module pbalu_bitop
    import pbalu_pkg::*;
#(
    parameter int DW    = 8,
    parameter int IDX_W = $clog2(DW)
) (
    input  op_class_e        cls,
    input  logic [DW-1:0]    operand,
    input  logic [IDX_W-1:0] bit_idx,
    output logic [DW-1:0]    res,
    output logic             tested
);

    logic [DW-1:0] hit;
    logic          do_write;
    logic          fill;

    // Write only for clear/force; fill value is 1 only for force.
    assign do_write = (cls == CLS_CLEAR) || (cls == CLS_FORCE);
    assign fill     = (cls == CLS_FORCE);

    // One lane per operand bit: decode the index and replace the hit bit.
    for (genvar i = 0; i < DW; i++) begin : g_lane
        assign hit[i] = (bit_idx == IDX_W'(i));
        assign res[i] = (do_write && hit[i]) ? fill : operand[i];
    end

    // Tested bit is the operand bit at the decoded position.
    assign tested = |(operand & hit);

endmodule

// File: rtl/pbalu_core.sv
// Module: pbalu_core (top)
// Combinational execution unit for second-table opcodes: decodes the
// class, runs the shifter or bit unit, and forms flags, mask and write-back.
// Assumes the core applies flags_mask and wr_en; no state is held here.
module pbalu_core
    import pbalu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [7:0]    opcode,
    input  logic [DW-1:0] operand,
    input  logic [3:0]    flags_in,
    output logic [DW-1:0] result,
    output logic          wr_en,
    output logic [3:0]    flags_out,
    output logic [3:0]    flags_mask
);

    localparam int IDX_W = $clog2(DW);

    op_class_e        cls;
    logic [IDX_W-1:0] bit_idx;
    logic [DW-1:0]    sh_res, bo_res;
    logic             sh_carry, tested;
    flag_t            fin, fnext;
    logic             is_shift;

    assign fin      = flag_t'(flags_in);
    assign is_shift = (opcode[7:6] == 2'b00);

    pbalu_decode #(.IDX_W(IDX_W)) u_dec (
        .opcode  (opcode),
        .cls     (cls),
        .bit_idx (bit_idx)
    );

    pbalu_shifter #(.DW(DW)) u_shf (
        .cls       (cls),
        .operand   (operand),
        .carry_in  (fin.c),
        .res       (sh_res),
        .carry_out (sh_carry)
    );

    pbalu_bitop #(.DW(DW), .IDX_W(IDX_W)) u_bit (
        .cls     (cls),
        .operand (operand),
        .bit_idx (bit_idx),
        .res     (bo_res),
        .tested  (tested)
    );

    // Choose result, write-back, flags and mask by operation group.
    always_comb begin
        fnext      = fin;
        flags_mask = 4'b0000;
        wr_en      = 1'b1;
        result     = bo_res;
        if (is_shift) begin
            result     = sh_res;
            fnext.z    = (sh_res == '0);
            fnext.n    = 1'b0;
            fnext.h    = 1'b0;
            fnext.c    = sh_carry;
            flags_mask = 4'b1111;
        end else if (cls == CLS_TEST) begin
            result     = operand;
            wr_en      = 1'b0;
            fnext.z    = ~tested;
            fnext.n    = 1'b0;
            fnext.h    = 1'b1;
            flags_mask = 4'b1110;
        end
    end

    assign flags_out = fnext;

endmodule

// File: rtl/pbalu_checker.sv
// Module: pbalu_checker
// Property checks on pbalu_core, attached through bind. The unit has no
// clock, so every check is an immediate assertion on settled values.
module pbalu_checker (
    input logic [7:0] opcode,
    input logic [7:0] operand,
    input logic [3:0] flags_in,
    input logic [7:0] result,
    input logic       wr_en,
    input logic [3:0] flags_out,
    input logic [3:0] flags_mask
);

    logic [7:0] sel_mask;

    assign sel_mask = 8'd1 << opcode[5:3];

    // Evaluate all group rules whenever inputs or outputs move.
    always_comb begin
        if (opcode[7:6] == 2'b00) begin
            assert_zero_flag_R6: assert (flags_out[3] == (result == 8'h00))
                else $error("R6 zero flag mismatch");
            assert_full_mask_R6: assert (flags_mask == 4'b1111 && wr_en && flags_out[2:1] == 2'b00)
                else $error("R6 mask/wr/NH mismatch");
        end
        if (opcode[7:3] == 5'b00110) begin
            assert_swap_halves_R5: assert (result == {operand[3:0], operand[7:4]} && !flags_out[0])
                else $error("R5 swap mismatch");
        end
        if (opcode[7:4] == 4'b0000) begin
            assert_circ_carry_R2: assert (flags_out[0] == (opcode[3] ? operand[0] : operand[7]))
                else $error("R2 carry mismatch");
        end
        if (opcode[7:6] == 2'b01) begin
            assert_test_nowrite_R7: assert (!wr_en && result == operand && flags_out[0] == flags_in[0]
                                            && flags_mask == 4'b1110)
                else $error("R7 test side effect");
        end
        if (opcode[7] == 1'b1) begin
            assert_other_bits_R8: assert ((result & ~sel_mask) == (operand & ~sel_mask)
                                          && flags_out == flags_in && flags_mask == 4'b0000)
                else $error("R8 untouched bits changed");
            assert_target_bit_R8: assert (((result & sel_mask) != 0) == opcode[6])
                else $error("R8 target bit wrong");
        end
    end

endmodule

bind pbalu_core pbalu_checker u_chk (
    .opcode     (opcode),
    .operand    (operand),
    .flags_in   (flags_in),
    .result     (result),
    .wr_en      (wr_en),
    .flags_out  (flags_out),
    .flags_mask (flags_mask)
);

// File: tb/pbalu_core_test.sv
// Bench: exhaustive sweep of opcode x operand x carry-in against an
// arithmetic model; one vector per clock, checked at the falling edge.
module pbalu_core_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] opcode = '0;
    logic [7:0] operand = '0;
    logic [3:0] flags_in = '0;
    logic [7:0] result;
    logic       wr_en;
    logic [3:0] flags_out;
    logic [3:0] flags_mask;

    int  n_chk = 0;
    int  n_bad = 0;
    int  wd    = 0;
    bit  done  = 1'b0;

    always #2.5 clk = ~clk;

    pbalu_core uut (
        .opcode     (opcode),
        .operand    (operand),
        .flags_in   (flags_in),
        .result     (result),
        .wr_en      (wr_en),
        .flags_out  (flags_out),
        .flags_mask (flags_mask)
    );

    // Expected {result, wr_en, flags_out, flags_mask}, built arithmetically.
    function automatic logic [16:0] model(input int op, input int a, input int fl);
        int r, c, z, top, sub, ci;
        top = op / 64;
        sub = (op / 8) % 8;
        ci  = fl % 2;
        if (top == 0) begin
            case (sub)
                0: begin r = (a * 2 + a / 128) % 256;   c = a / 128; end
                1: begin r = a / 2 + (a % 2) * 128;     c = a % 2;   end
                2: begin r = (a * 2 + ci) % 256;        c = a / 128; end
                3: begin r = a / 2 + ci * 128;          c = a % 2;   end
                4: begin r = (a * 2) % 256;             c = a / 128; end
                5: begin r = a / 2 + (a / 128) * 128;   c = a % 2;   end
                6: begin r = (a % 16) * 16 + a / 16;    c = 0;       end
                default: begin r = a / 2;               c = a % 2;   end
            endcase
            z = (r == 0) ? 1 : 0;
            return {8'(r), 1'b1, 1'(z), 2'b00, 1'(c), 4'b1111};
        end else if (top == 1) begin
            z = ((a >> sub) % 2 == 0) ? 1 : 0;
            return {8'(a), 1'b0, 1'(z), 1'b0, 1'b1, 1'(ci), 4'b1110};
        end else begin
            r = (a >> sub) % 2 == 1 ? a - (1 << sub) : a;
            if (top == 3) r = r + (1 << sub);
            return {8'(r), 1'b1, 4'(fl), 4'b0000};
        end
    endfunction

    task automatic check(input string tag, input logic [16:0] act, input logic [16:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s op=%02h a=%02h f=%b actual=%05h expected=%05h",
                     tag, opcode, operand, flags_in, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 190000 && !done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        string tag;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Quiet-input state: opcode 0, operand 0 gives zero result, Z set (R6).
        @(negedge clk);
        check("R6 idle", {result, wr_en, flags_out, flags_mask}, {8'h00, 1'b1, 4'b1000, 4'b1111});
        for (int op = 0; op < 256; op++) begin
            if (op < 64) begin
                case ((op / 8) % 8)
                    0, 1:    tag = "R1 R2 R6";
                    2, 3:    tag = "R1 R3 R6";
                    6:       tag = "R1 R5 R6";
                    default: tag = "R1 R4 R6";
                endcase
            end else if (op < 128) tag = "R7";
            else tag = "R8";
            if (op % 8 != 0) tag = {tag, " R9"};
            for (int a = 0; a < 256; a++) begin
                for (int ci = 0; ci < 2; ci++) begin
                    int fl;
                    fl = ((a / 2 + op) % 2) * 8 + ((a / 4) % 2) * 4 + ((a / 32 + op / 8) % 2) * 2 + ci;
                    @(posedge clk);
                    opcode   <= 8'(op);
                    operand  <= 8'(a);
                    flags_in <= 4'(fl);
                    @(negedge clk);
                    check(tag, {result, wr_en, flags_out, flags_mask}, model(op, a, fl));
                end
            end
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule